// File: doc/BRIEF.md
# Word-Serial Arithmetic Right Shifter

This block shifts a signed multi-word operand right by an arbitrary number of bits and sends out the result one word per cycle. It starts with the least significant word. The operand sits in an external register file with one combinational read port. The block drives the read address and takes back the word on the same cycle. The shift amount is split into a whole-word part and a bit part. The whole-word part offsets the read address. The bit part steers a funnel shifter that is two words wide. A holding register keeps the word read on the previous cycle, so the funnel always sees the two source words that an output word straddles.

An operation starts with a one-cycle `start` pulse that carries the shift amount and the word count. In that same cycle the block reads the most significant word to capture the operand sign. One preload cycle then fills the holding register. After that, one result word comes out on each of the next `nwords` cycles. Source positions above the top word are never read. The sign fill is used in their place.

Top module: `wserial_rshift`

## Requirements
- R1: After reset the block is idle: `busy` and `out_valid` are low.
- R2: A `start` pulse in the idle state with 1 <= `nwords` <= MAXW is taken. `busy` is high on the next cycle while `out_valid` stays low for that single preload cycle. After that, `out_valid` is high on exactly `nwords` consecutive cycles.
- R3: Output word k (k = 0 first, the least significant) equals bits [k*W +: W] of the operand arithmetically shifted right by `shamt`. The operand is formed from register-file words 0 (LSW) to `nwords`-1 (MSW), and its sign is bit W-1 of word `nwords`-1.
- R4: When `shamt` is a multiple of W, output word k equals register-file word k + `shamt`/W unchanged, wherever that index is below `nwords`.
- R5: Source positions at or above `nwords` read as all ones for a negative operand and as all zeros otherwise. A shift of `nwords`*W bits or more therefore gives words made only of sign bits.
- R6: `out_last` is high together with the final output word only. `busy` is low on the cycle after it.
- R7: A `start` pulse while `busy` is high is ignored. The running sequence continues unchanged.
- R8: A `start` pulse with `nwords` equal to 0 or above MAXW is ignored. The block stays idle.
- R9: While busy, `rd_en` is asserted only with `rd_addr` below the accepted word count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| shamt | input | SHW | Right shift amount in bits |
| nwords | input | CW | Operand length in words |
| busy | output | 1 | Operation in progress |
| rd_en | output | 1 | Register-file read strobe |
| rd_addr | output | AW | Register-file word address |
| rd_data | input | W | Register-file word, valid in the same cycle |
| out_valid | output | 1 | Result word valid |
| out_word | output | W | Result word |
| out_last | output | 1 | Marks the most significant result word |

## Verification
Positive and negative operands are shifted by zero and by whole-word amounts. These cases separate address-offset errors from funnel errors. Shifts with a nonzero bit part, including one bit below a word boundary, expose a wrong half of the funnel or a stale holding register. Shifts that reach past the top word, including shifts far beyond the whole operand, show whether the sign fill replaces out-of-range reads. Single-word operands and `start` pulses during a run or with illegal counts test the edges of the control sequence.

// File: rtl/wserial_rshift.sv
module wserial_rshift #(
  parameter int W    = 16,
  parameter int MAXW = 8,
  localparam int LW  = $clog2(W),
  localparam int AW  = $clog2(MAXW),
  localparam int CW  = $clog2(MAXW + 1),
  localparam int SHW = $clog2(W * MAXW) + 1,
  localparam int IW  = SHW - LW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [SHW-1:0] shamt,
  input  logic [CW-1:0]  nwords,
  output logic           busy,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  input  logic [W-1:0]   rd_data,
  output logic           out_valid,
  output logic [W-1:0]   out_word,
  output logic           out_last
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN} st_t;
  st_t st;

  logic          sgn;
  logic [LW-1:0] rsh;
  logic [IW-1:0] src;
  logic [CW-1:0] cnt, k;
  logic [W-1:0]  aux;

  wire go     = (st == S_IDLE) && start && (nwords != '0) && (nwords <= CW'(MAXW));
  wire in_rng = src < {{(IW-CW){1'b0}}, cnt};
  wire [W-1:0]   cur  = in_rng ? rd_data : {W{sgn}};
  wire [2*W-1:0] fun  = {cur, aux} >> rsh;
  wire [CW-1:0]  nm1  = nwords - 1'b1;

  assign busy      = (st != S_IDLE);
  assign rd_en     = go || (busy && in_rng);
  assign rd_addr   = go ? nm1[AW-1:0] : src[AW-1:0];
  assign out_valid = (st == S_RUN);
  assign out_word  = fun[W-1:0];
  assign out_last  = out_valid && (k == cnt - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      sgn <= 1'b0;
      rsh <= '0;
      src <= '0;
      cnt <= '0;
      k   <= '0;
      aux <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          sgn <= rd_data[W-1];
          rsh <= shamt[LW-1:0];
          src <= {1'b0, shamt[SHW-1:LW]};
          cnt <= nwords;
          st  <= S_LOAD;
        end
        S_LOAD: begin
          aux <= cur;
          src <= src + 1'b1;
          k   <= '0;
          st  <= S_RUN;
        end
        S_RUN: begin
          aux <= cur;
          src <= src + 1'b1;
          k   <= k + 1'b1;
          if (out_last) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module wserial_rshift_chk #(
  parameter int MAXW = 8,
  localparam int AW  = $clog2(MAXW),
  localparam int CW  = $clog2(MAXW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] nwords,
  input logic          busy,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          out_valid,
  input logic          out_last,
  input logic [CW-1:0] cnt
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && nwords != '0 && nwords <= CW'(MAXW)) |=> (busy && !out_valid));
  p_stream_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);
  p_valid_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  p_last_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !busy);
  p_bad_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (nwords == '0 || nwords > CW'(MAXW))) |=> !busy);
  p_rd_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |-> ({1'b0, rd_addr} < {1'b0, cnt}));
endmodule

bind wserial_rshift wserial_rshift_chk #(.MAXW(MAXW)) u_chk (.*);

// File: tb/test_wserial_rshift.sv
module test_wserial_rshift;
  localparam int W    = 16;
  localparam int MAXW = 8;
  localparam int AW   = $clog2(MAXW);
  localparam int CW   = $clog2(MAXW + 1);
  localparam int SHW  = $clog2(W * MAXW) + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [SHW-1:0] shamt = '0;
  logic [CW-1:0]  nwords = '0;
  logic busy, rd_en, out_valid, out_last;
  logic [AW-1:0] rd_addr;
  logic [W-1:0]  rd_data, out_word;
  logic [W-1:0]  mem [MAXW];
  int checks = 0, fails = 0;

  always #4 clk = ~clk;
  assign rd_data = mem[rd_addr];

  wserial_rshift #(.W(W), .MAXW(MAXW)) i_wserial_rshift (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int n, input int seed, input bit neg);
    for (int j = 0; j < MAXW; j++) mem[j] = W'(seed * (j + 3) * 40503 + j * 7919);
    mem[n-1][W-1] = neg;
  endtask

  task automatic run(input int n, input int sh, input string req, input bit poke);
    logic signed [W*MAXW-1:0] v;
    v = '0;
    for (int j = 0; j < MAXW; j++)
      v[j*W +: W] = (j < n) ? mem[j] : {W{mem[n-1][W-1]}};
    v = v >>> sh;
    @(negedge clk);
    start = 1'b1; shamt = SHW'(sh); nwords = CW'(n);
    @(negedge clk);
    start = 1'b0;
    chk(busy && !out_valid, "R2", "preload cycle busy/valid", {14'b0, busy, out_valid}, 16'h2);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      chk(out_valid, "R2", "word valid", {15'b0, out_valid}, 16'h1);
      chk(out_word == v[k*W +: W], req, $sformatf("word %0d shift %0d", k, sh),
          out_word, v[k*W +: W]);
      chk(out_last == (k == n - 1), "R6", "last flag", {15'b0, out_last}, {15'b0, k == n - 1});
      if (poke && k == 0) begin
        start = 1'b1; nwords = 2; shamt = 1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(!busy && !out_valid, "R6", "idle after last", {14'b0, busy, out_valid}, 16'h0);
  endtask

  task automatic bad(input int n);
    @(negedge clk);
    start = 1'b1; nwords = CW'(n); shamt = 3;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !out_valid, "R8", $sformatf("count %0d ignored", n), {14'b0, busy, out_valid}, 16'h0);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL R2 watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    fill(MAXW, 1, 1'b0);
    repeat (2) @(negedge clk);
    chk(!busy && !out_valid, "R1", "reset idle", {14'b0, busy, out_valid}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !out_valid, "R1", "idle after reset release", {14'b0, busy, out_valid}, 16'h0);

    fill(8, 5, 1'b0);  run(8, 0,   "R4", 1'b0);
    fill(8, 6, 1'b1);  run(8, 32,  "R4", 1'b0);
    fill(8, 7, 1'b0);  run(8, 5,   "R3", 1'b0);
    fill(8, 8, 1'b1);  run(8, 37,  "R3", 1'b0);
    fill(8, 9, 1'b1);  run(8, 15,  "R3", 1'b0);
    fill(8, 10, 1'b1); run(8, 127, "R5", 1'b0);
    fill(8, 11, 1'b0); run(8, 100, "R5", 1'b0);
    fill(3, 12, 1'b1); run(3, 200, "R5", 1'b0);
    fill(3, 13, 1'b0); run(3, 48,  "R5", 1'b0);
    fill(1, 14, 1'b1); run(1, 3,   "R3", 1'b0);
    fill(4, 15, 1'b0); run(4, 16,  "R4", 1'b0);
    fill(5, 16, 1'b1); run(5, 21,  "R7", 1'b1);
    fill(6, 17, 1'b0); run(6, 9,   "R7", 1'b1);
    bad(0);
    bad(MAXW + 1);
    fill(2, 18, 1'b1); run(2, 17, "R3", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule